// File: doc/BRIEF.md
# Address Hold Loop Generator

This block produces the byte addresses for the two sides of a memory copy channel, one address stream for the read side and one for the write side. Each side takes a start address and then moves forward by one byte on every advance strobe. In free mode the address counts up without limit. In hold mode it stays inside a small window that begins at the start address and wraps back to it. This lets one side keep hitting a FIFO-style peripheral that sits behind a few consecutive byte addresses.

Both sides take their settings from one shared mode word. Each side has its own hold-enable bit and its own 2-bit window code. The code is the base-2 logarithm of the window size, so the window is 1, 2, 4 or 8 bytes. Each side copies its settings from the mode word when its start address is loaded. The window is measured as an offset from the start address, so the start address does not need to be aligned. A side moves no data and drives no bus signals. It only supplies the address for the next byte.

Top module: `dma_addr_loop_gen`

## Requirements
- R1: While reset is held and until the first load, both address outputs are zero.
- R2: Loading a side sets its address output to the supplied start address on the next cycle and clears its offset to zero.
- R3: With hold disabled, each advance raises the address of that side by exactly one. Carries cross any boundary, and the address wraps modulo 2^ADDR_W.
- R4: With hold enabled and window code 2, repeated advances give base, base+1, base+2, base+3, then base again, repeating.
- R5: The window size is 2 to the power of the window code (codes 0..3 give 1, 2, 4, 8 bytes). With code 0 the address stays at the base.
- R6: An unaligned base still gives exactly window-size consecutive addresses starting at the base, even when they cross an aligned boundary.
- R7: Mode word layout: bit 12 enables hold for the source side (index 0), and bits 15:14 hold its window code. Bit 13 enables hold for the destination side (index 1), and bits 17:16 hold its window code. All other bits have no effect.
- R8: The two sides are independent. A load or advance on one side never changes the address of the other side.
- R9: A side captures its hold settings only when it is loaded. Later changes to the mode word have no effect until the next load.
- R10: When load and advance are both asserted for a side in the same cycle, the load wins and the output is the new base.
- R11: With neither load nor advance asserted, a side keeps its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | MODE_W (32) | Mode word that carries the hold-enable bits and window codes of both sides |
| load_i | input | 2 | Per-side load strobe: bit 0 is source, bit 1 is destination |
| base_i | input | 2*ADDR_W (64) | Per-side start address: bits 31:0 are source, bits 63:32 are destination |
| adv_i | input | 2 | Per-side advance strobe, one byte per assertion |
| addr_o | output | 2*ADDR_W (64) | Per-side current address, same packing as base_i |

## Verification
Every result is registered. The address for a load or an advance shows up one clock edge after the strobe is sampled, and an idle cycle leaves the address as it was. Leaving reset adds two cycles for the reset synchronizer before strobes take effect. The bench changes inputs on the falling edge and holds each strobe for exactly one rising edge. It reads the outputs at the next falling edge, which falls exactly in the cycle the new address is due. The expected values come from the base, the step count and the window size given in the requirements.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

  // side indices
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;
  localparam int NUM_SIDES = 2;

  // window code width: window = 2**code bytes
  localparam int WIN_CODE_W = 2;

  // mode word field positions (decoded by the channel mode logic)
  localparam int SRC_HOLD_BIT  = 12;
  localparam int DST_HOLD_BIT  = 13;
  localparam int SRC_CODE_LSB  = 14;
  localparam int DST_CODE_LSB  = 16;
  localparam int MODE_MIN_W    = 18;

  typedef struct packed {
    logic                  hold;
    logic [WIN_CODE_W-1:0] code;
  } loop_cfg_t;

  function automatic int hold_bit_of(input int side);
    return (side == SIDE_SRC) ? SRC_HOLD_BIT : DST_HOLD_BIT;
  endfunction

  function automatic int code_lsb_of(input int side);
    return (side == SIDE_SRC) ? SRC_CODE_LSB : DST_CODE_LSB;
  endfunction

endpackage

// File: rtl/dma_loop_mode_decode.sv
module dma_loop_mode_decode
  import dma_loop_pkg::*;
#(
  parameter int MODE_W = 32
) (
  input  logic [MODE_W-1:0]               mode_i,
  output loop_cfg_t [NUM_SIDES-1:0]       cfg_o
);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int HB = hold_bit_of(s);
    localparam int CL = code_lsb_of(s);

    assign cfg_o[s].hold = mode_i[HB];
    assign cfg_o[s].code = mode_i[CL +: WIN_CODE_W];
  end

  // layout sanity on the elaborated width (R7)
  always_comb begin
    assert (MODE_W >= MODE_MIN_W)
      else $error("p_mode_width_r7: mode word too narrow");
  end

endmodule

// File: rtl/dma_loop_offset.sv
module dma_loop_offset
  import dma_loop_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  step_i,
  input  logic                  hold_i,
  input  logic [WIN_CODE_W-1:0] code_i,
  output logic [OFF_W-1:0]      off_q,
  output logic [OFF_W-1:0]      off_d
);

  localparam logic [OFF_W-1:0] ONES = {OFF_W{1'b1}};

  logic [OFF_W-1:0] win_mask;
  logic [OFF_W-1:0] off_inc;
  logic             off_en;

  // window mask: all ones in free mode, 2**code - 1 in hold mode
  always_comb begin
    win_mask = hold_i ? ~(ONES << code_i) : ONES;
  end

  // next-state logic
  always_comb begin
    off_inc = (off_q + 1'b1) & win_mask;
    off_en  = clr_i | step_i;
    if (clr_i) begin
      off_d = '0;
    end else if (step_i) begin
      off_d = off_inc;
    end else begin
      off_d = off_q;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  // offset never leaves the window while holding (R6)
  p_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> ((off_q & ~win_mask) == '0));

  // offset returns to zero after the last window byte (R4)
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && hold_i && (off_q == win_mask)) |=> (off_q == '0));

  // a clear always lands on zero (R2)
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (off_q == '0));

endmodule

// File: rtl/dma_loop_side.sv
module dma_loop_side
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  loop_cfg_t         cfg_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  loop_cfg_t         cfg_q, cfg_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic              step;
  logic              upd_en;

  // load has priority over advance (R10)
  assign step = adv_i & ~load_i;

  dma_loop_offset #(
    .OFF_W (ADDR_W)
  ) u_offset (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_i),
    .step_i (step),
    .hold_i (cfg_q.hold),
    .code_i (cfg_q.code),
    .off_q  (off_q),
    .off_d  (off_d)
  );

  // next-state logic
  always_comb begin
    upd_en = load_i | adv_i;
    base_d = base_q;
    cfg_d  = cfg_q;
    addr_d = addr_q;
    if (load_i) begin
      base_d = base_i;
      cfg_d  = cfg_i;
      addr_d = base_i;
    end else if (adv_i) begin
      addr_d = base_q + off_d;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(base_i)));

  p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !cfg_q.hold) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  p_cfg_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cfg_q));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(addr_o));

  p_base_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q));

endmodule

// File: rtl/dma_addr_loop_gen.sv
module dma_addr_loop_gen
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             mode_i,
  input  logic [NUM_SIDES-1:0]          load_i,
  input  logic [NUM_SIDES*ADDR_W-1:0]   base_i,
  input  logic [NUM_SIDES-1:0]          adv_i,
  output logic [NUM_SIDES*ADDR_W-1:0]   addr_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]    rst_sync_q;
  logic                      rst_n_int;
  loop_cfg_t [NUM_SIDES-1:0] side_cfg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  dma_loop_mode_decode #(
    .MODE_W (MODE_W)
  ) u_decode (
    .mode_i (mode_i),
    .cfg_o  (side_cfg)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dma_loop_side #(
      .ADDR_W (ADDR_W)
    ) u_side (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .load_i (load_i[s]),
      .base_i (base_i[s*ADDR_W +: ADDR_W]),
      .adv_i  (adv_i[s]),
      .cfg_i  (side_cfg[s]),
      .addr_o (addr_o[s*ADDR_W +: ADDR_W])
    );
  end

  // outputs are zero whenever the internal reset is active (R1)
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n_int |=> (!rst_n_int ? (addr_o == '0) : 1'b1));

endmodule

// File: tb/tb_dma_addr_loop_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_loop_gen;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   mode = '0;
  logic [1:0]    load = '0;
  logic [63:0]   base = '0;
  logic [1:0]    adv = '0;
  logic [63:0]   addr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] JUNK = 32'hFFFC_0FFF;

  always #2 clk = ~clk;

  dma_addr_loop_gen dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .load_i (load),
    .base_i (base),
    .adv_i  (adv),
    .addr_o (addr)
  );

  function automatic logic [31:0] mk_mode(bit s_en, int s_code, bit d_en, int d_code);
    logic [31:0] m = '0;
    m[12]    = s_en;
    m[15:14] = s_code[1:0];
    m[13]    = d_en;
    m[17:16] = d_code[1:0];
    return m;
  endfunction

  function automatic logic [31:0] addr_of(int s);
    return addr[s*AW +: AW];
  endfunction

  function automatic logic [31:0] expect_addr(logic [31:0] b, bit hold, int code, int k);
    if (hold) return b + 32'(k % (1 << code));
    return b + 32'(k);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_side(int s, logic [31:0] b, logic [31:0] m);
    @(negedge clk);
    mode = m;
    base[s*AW +: AW] = b;
    load[s] = 1'b1;
    @(negedge clk);
    load[s] = 1'b0;
  endtask

  task automatic step(int s);
    @(negedge clk);
    adv[s] = 1'b1;
    @(negedge clk);
    adv[s] = 1'b0;
  endtask

  task automatic run_window(string req, int s, logic [31:0] b, bit hold, int code, int n);
    for (int k = 1; k <= n; k++) begin
      step(s);
      check(req, addr_of(s), expect_addr(b, hold, code, k));
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 src", addr_of(0), 32'h0);
    check("R1 dst", addr_of(1), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 src after release", addr_of(0), 32'h0);
    check("R1 dst after release", addr_of(1), 32'h0);
  endtask

  task automatic t_load;
    load_side(0, 32'h0000_1000, mk_mode(0, 0, 0, 0));
    check("R2 load src", addr_of(0), 32'h0000_1000);
    load_side(1, 32'h8000_0040, mk_mode(0, 0, 0, 0));
    check("R2 load dst", addr_of(1), 32'h8000_0040);
    step(1);
    check("R2 offset cleared", addr_of(1), 32'h8000_0041);
  endtask

  task automatic t_free_run;
    load_side(0, 32'h0000_00FC, mk_mode(0, 3, 0, 3));
    run_window("R3 free increment", 0, 32'h0000_00FC, 0, 0, 10);
    load_side(0, 32'hFFFF_FFFE, mk_mode(0, 2, 0, 0));
    run_window("R3 top wrap", 0, 32'hFFFF_FFFE, 0, 0, 3);
  endtask

  task automatic t_hold4;
    load_side(0, 32'h0000_2000, mk_mode(1, 2, 0, 0));
    run_window("R4 window of four", 0, 32'h0000_2000, 1, 2, 9);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 4; c++) begin
      load_side(1, 32'h0000_4000, mk_mode(0, 0, 1, c));
      check("R5 load", addr_of(1), 32'h0000_4000);
      run_window("R5 window size", 1, 32'h0000_4000, 1, c, 2 * (1 << c) + 1);
    end
  endtask

  task automatic t_unaligned;
    load_side(0, 32'h0000_30FE, mk_mode(1, 2, 0, 0));
    run_window("R6 unaligned window", 0, 32'h0000_30FE, 1, 2, 8);
    load_side(1, 32'h0000_5005, mk_mode(0, 0, 1, 3));
    run_window("R6 unaligned window of eight", 1, 32'h0000_5005, 1, 3, 10);
  endtask

  task automatic t_fields;
    logic [31:0] m;
    m = JUNK | mk_mode(1, 1, 0, 3);
    load_side(0, 32'h0000_0100, m);
    run_window("R7 source field", 0, 32'h0000_0100, 1, 1, 3);
    load_side(1, 32'h0000_0200, m);
    run_window("R7 destination enable clear", 1, 32'h0000_0200, 0, 0, 9);
    m = JUNK | mk_mode(0, 3, 1, 2);
    load_side(1, 32'h0000_0300, m);
    run_window("R7 destination field", 1, 32'h0000_0300, 1, 2, 5);
    load_side(0, 32'h0000_0400, m);
    run_window("R7 source enable clear", 0, 32'h0000_0400, 0, 0, 9);
  endtask

  task automatic t_independent;
    load_side(0, 32'h0000_6000, mk_mode(0, 0, 0, 0));
    load_side(1, 32'h0000_7000, mk_mode(0, 0, 0, 0));
    step(0);
    step(0);
    check("R8 dst untouched by src advance", addr_of(1), 32'h0000_7000);
    load_side(1, 32'h0000_7100, mk_mode(0, 0, 0, 0));
    check("R8 src untouched by dst load", addr_of(0), 32'h0000_6002);
    @(negedge clk);
    adv = 2'b11;
    @(negedge clk);
    adv = 2'b00;
    check("R8 joint advance src", addr_of(0), 32'h0000_6003);
    check("R8 joint advance dst", addr_of(1), 32'h0000_7101);
  endtask

  task automatic t_capture;
    load_side(0, 32'h0000_0500, mk_mode(1, 1, 0, 0));
    @(negedge clk);
    mode = mk_mode(0, 3, 1, 3);
    run_window("R9 settings kept after mode change", 0, 32'h0000_0500, 1, 1, 4);
  endtask

  task automatic t_load_wins;
    load_side(0, 32'h0000_0A00, mk_mode(0, 0, 0, 0));
    step(0);
    @(negedge clk);
    mode = mk_mode(0, 0, 0, 0);
    base[31:0] = 32'h0000_7000;
    load[0] = 1'b1;
    adv[0] = 1'b1;
    @(negedge clk);
    load[0] = 1'b0;
    adv[0] = 1'b0;
    check("R10 load beats advance", addr_of(0), 32'h0000_7000);
    step(0);
    check("R10 next advance", addr_of(0), 32'h0000_7001);
  endtask

  task automatic t_idle;
    load_side(1, 32'h0000_0C00, mk_mode(0, 0, 1, 2));
    step(1);
    repeat (5) @(negedge clk);
    check("R11 dst idle", addr_of(1), 32'h0000_0C01);
    check("R11 src idle", addr_of(0), 32'h0000_7001);
  endtask

  initial begin
    t_reset();
    t_load();
    t_free_run();
    t_hold4();
    t_codes();
    t_unaligned();
    t_fields();
    t_independent();
    t_capture();
    t_load_wins();
    t_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule